// File: doc/BRIEF.md
# Dual-Channel DMA Control and Status Registers

This block is the software-visible register file of a descriptor-driven DMA engine that has a transmit channel and a receive channel. A simple 32-bit register bus addresses both channels. The address picks the channel and the register. Each channel keeps a control word, a status word, a current-descriptor pointer and a tail-descriptor pointer. The block drives the run, halted and idle state to the transfer engine. It also gives the engine a one-clock start pulse whenever software moves the transmit tail pointer.

Completion counting and the delay timer live outside this block. Their live 8-bit values come in on input pins and appear only in status reads. A soft-reset bit in the control word returns a channel to its power-up state. The bit stays set until software reads the control word, and while it is set it blocks the channel from starting. The tail-pointer mode bit cannot be cleared and always reads as 1. The bus is plain, with no back-pressure: a write takes effect on the clock edge that samples it, and a read returns data with a valid flag one clock later.

Top module: `dma_chan_regs`

## Requirements
- R1: Channel windows are 48 bytes wide. The channel is bit 0 of (address / 48): 0 is transmit and 1 is receive, so address 0x60 aliases transmit. Inside a window the register index is (offset / 4): 0 selects control, 1 status, 2 current descriptor and 4 tail descriptor. Every other index reads as zero, and writes to it change nothing.
- R2: After reset, each control word is 0x00010002 (threshold field bits 23:16 = 1, mode bit 1 set) and each stored status is 0x0001 (halted). Both pointers are zero, run and idle are low, halted is high, the start pulse is low and read-valid is low.
- R3: A control write stores the written word with bit 1 forced to 1, and a pending soft-reset bit (bit 2) is kept. The channel's run output follows control bit 0.
- R4: A control write that ends with bit 0 set and bit 2 clear clears status bit 0 (halted) and status bit 1 (idle). Both outputs change on the edge that samples the write.
- R5: A control write whose resulting bit 2 is set, either from the written data or from a reset still pending, loads control with 0x00010006 and status with 0x0001. Run is ignored in that case.
- R6: A control read returns the stored word, including a pending reset bit, and then clears bit 2. The next read no longer shows that bit.
- R7: A status read returns {delay value[7:0], completion count[7:0], stored status[15:0]} for the addressed channel. A status write stores data bits 15:0 with bits 14:12 forced to zero.
- R8: A tail write stores the pointer and clears idle on that channel. On the transmit channel only, it raises `tx_kick` for exactly the one clock that follows the write.
- R9: A read sampled on a clock edge drives `bus_rdata` and raises `bus_rvalid` on that edge, for one clock. A cycle with both `bus_wr` and `bus_rd` high performs only the write and gives no read-valid.
- R10: The descriptor registers store full 32-bit words, read back the stored value and drive the `cur_desc`/`tail_desc` outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one clock after the read |
| cmpl_cnt | input | 16 | Live completion counts, transmit in bits 7:0, receive in 15:8 |
| dly_cnt | input | 16 | Live delay-timer values, transmit in bits 7:0, receive in 15:8 |
| ch_run | output | 2 | Run bit per channel (bit 0 transmit) |
| ch_halted | output | 2 | Halted status per channel |
| ch_idle | output | 2 | Idle status per channel |
| cur_desc | output | 64 | Current descriptor pointers, transmit in bits 31:0 |
| tail_desc | output | 64 | Tail descriptor pointers, transmit in bits 31:0 |
| tx_kick | output | 1 | One-clock start pulse after a transmit tail write |

## Verification
Every state output, pointer output and `tx_kick` changes on the same edge that samples the write. Read data and its valid flag arrive on the edge that samples the read. The bench drives on the falling edge and samples at the next falling edge, so each check sits half a clock after the register that produces the result. It watches `tx_kick` at two falling edges in a row to show that the pulse lasts exactly one clock. It reads control twice in a row to show that the reset bit is returned by the first read and gone by the second.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int NUM_CH     = 2;
  localparam int DATA_W     = 32;
  localparam int STAT_W     = 16;
  localparam int CNT_W      = 8;
  localparam int WIN_BYTES  = 48;

  localparam int IDX_CTRL   = 0;
  localparam int IDX_STAT   = 1;
  localparam int IDX_CUR    = 2;
  localparam int IDX_TAIL   = 4;

  localparam int CTL_RUN    = 0;
  localparam int CTL_TPM    = 1;
  localparam int CTL_SRST   = 2;
  localparam int ST_HALT    = 0;
  localparam int ST_IDLE    = 1;

  localparam logic [DATA_W-1:0] CTL_RESET_VAL = 32'h0001_0002;
  localparam logic [STAT_W-1:0] ST_RESET_VAL  = 16'h0001;
  localparam logic [STAT_W-1:0] ST_IRQ_MASK   = 16'h7000;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_CTRL,
    REG_STAT,
    REG_CUR,
    REG_TAIL
  } reg_sel_e;
endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              chan,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] WIN = ADDR_W'(WIN_BYTES);

  logic [ADDR_W-1:0] win_num;
  logic [ADDR_W-1:0] win_off;
  logic [ADDR_W-1:0] idx;

  always_comb begin
    win_num = addr / WIN;
    win_off = addr % WIN;
    idx     = win_off >> 2;
    chan    = win_num[0];
    if (idx == ADDR_W'(IDX_CTRL))      sel = REG_CTRL;
    else if (idx == ADDR_W'(IDX_STAT)) sel = REG_STAT;
    else if (idx == ADDR_W'(IDX_CUR))  sel = REG_CUR;
    else if (idx == ADDR_W'(IDX_TAIL)) sel = REG_TAIL;
    else                               sel = REG_NONE;
  end
endmodule

// File: rtl/dcr_chan.sv
module dcr_chan
  import dcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_stat,
  input  logic              wr_cur,
  input  logic              wr_tail,
  input  logic              rd_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [STAT_W-1:0] stat_q,
  output logic [DATA_W-1:0] cur_q,
  output logic [DATA_W-1:0] tail_q
);
  logic [DATA_W-1:0] ctrl_wv;

  always_comb begin
    ctrl_wv = wdata;
    ctrl_wv[CTL_TPM]  = 1'b1;
    ctrl_wv[CTL_SRST] = wdata[CTL_SRST] | ctrl_q[CTL_SRST];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTL_RESET_VAL;
      stat_q <= ST_RESET_VAL;
      cur_q  <= '0;
      tail_q <= '0;
    end else begin
      if (wr_ctrl) begin
        if (ctrl_wv[CTL_SRST]) begin
          ctrl_q           <= CTL_RESET_VAL;
          ctrl_q[CTL_SRST] <= 1'b1;
          stat_q           <= ST_RESET_VAL;
        end else begin
          ctrl_q <= ctrl_wv;
          if (ctrl_wv[CTL_RUN]) begin
            stat_q[ST_HALT] <= 1'b0;
            stat_q[ST_IDLE] <= 1'b0;
          end
        end
      end else if (rd_ctrl) begin
        ctrl_q[CTL_SRST] <= 1'b0;
      end
      if (wr_stat) stat_q <= wdata[STAT_W-1:0] & ~ST_IRQ_MASK;
      if (wr_cur)  cur_q  <= wdata;
      if (wr_tail) begin
        tail_q          <= wdata;
        stat_q[ST_IDLE] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dcr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NUM_CH*CNT_W-1:0]  cmpl_cnt,
  input  logic [NUM_CH*CNT_W-1:0]  dly_cnt,
  output logic [NUM_CH-1:0]        ch_run,
  output logic [NUM_CH-1:0]        ch_halted,
  output logic [NUM_CH-1:0]        ch_idle,
  output logic [NUM_CH*DATA_W-1:0] cur_desc,
  output logic [NUM_CH*DATA_W-1:0] tail_desc,
  output logic                     tx_kick
);
  logic     dch;
  reg_sel_e dsel;
  logic     rd_go;

  logic [DATA_W-1:0] ctrl_a [NUM_CH];
  logic [STAT_W-1:0] stat_a [NUM_CH];
  logic [DATA_W-1:0] cur_a  [NUM_CH];
  logic [DATA_W-1:0] tail_a [NUM_CH];
  logic [DATA_W-1:0] rmux;

  dcr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .chan (dch),
    .sel  (dsel)
  );

  assign rd_go = bus_rd && !bus_wr;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit = (dch == 1'(g));

    dcr_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_ctrl (bus_wr && hit && dsel == REG_CTRL),
      .wr_stat (bus_wr && hit && dsel == REG_STAT),
      .wr_cur  (bus_wr && hit && dsel == REG_CUR),
      .wr_tail (bus_wr && hit && dsel == REG_TAIL),
      .rd_ctrl (rd_go && hit && dsel == REG_CTRL),
      .wdata   (bus_wdata),
      .ctrl_q  (ctrl_a[g]),
      .stat_q  (stat_a[g]),
      .cur_q   (cur_a[g]),
      .tail_q  (tail_a[g])
    );

    assign ch_run[g]                    = ctrl_a[g][CTL_RUN];
    assign ch_halted[g]                 = stat_a[g][ST_HALT];
    assign ch_idle[g]                   = stat_a[g][ST_IDLE];
    assign cur_desc[g*DATA_W +: DATA_W]  = cur_a[g];
    assign tail_desc[g*DATA_W +: DATA_W] = tail_a[g];
  end

  always_comb begin
    case (dsel)
      REG_CTRL: rmux = ctrl_a[dch];
      REG_STAT: rmux = {dly_cnt[dch*CNT_W +: CNT_W],
                        cmpl_cnt[dch*CNT_W +: CNT_W],
                        stat_a[dch]};
      REG_CUR:  rmux = cur_a[dch];
      REG_TAIL: rmux = tail_a[dch];
      default:  rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_kick    <= 1'b0;
    end else begin
      bus_rvalid <= rd_go;
      if (rd_go) bus_rdata <= rmux;
      tx_kick <= bus_wr && !dch && dsel == REG_TAIL;
    end
  end
endmodule

// File: rtl/dcr_chk.sv
module dcr_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic [1:0]        ch_halted,
  input logic [1:0]        ch_idle,
  input logic              tx_kick
);
  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] win;
  logic              tx_tail_hit;
  logic              ctrl_hit;

  always_comb begin
    win         = bus_addr / ADDR_W'(48);
    off         = bus_addr % ADDR_W'(48);
    tx_tail_hit = !win[0] && (off >> 2) == ADDR_W'(4);
    ctrl_hit    = (off >> 2) == ADDR_W'(0);
  end

  a_r9_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> bus_rvalid);

  a_r9_no_rvalid: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && !bus_wr) |=> !bus_rvalid);

  a_r8_kick_source: assert property (@(posedge clk) disable iff (!rst_n)
    tx_kick |-> $past(bus_wr && tx_tail_hit));

  a_r3_mode_bit_reads_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rvalid && $past(ctrl_hit)) |-> bus_rdata[1]);

  for (genvar c = 0; c < 2; c++) begin : g_c
    a_r4_halt_clears_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ch_halted[c]) |-> $past(bus_wr));

    a_r7_idle_sets_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_idle[c]) |-> $past(bus_wr));
  end
endmodule

bind dma_chan_regs dcr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/dma_chan_regs_test.sv
module dma_chan_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [15:0] cmpl_cnt = 16'h115A;
  logic [15:0] dly_cnt  = 16'h22C3;
  logic [1:0]  ch_run, ch_halted, ch_idle;
  logic [63:0] cur_desc, tail_desc;
  logic        tx_kick;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_regs #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .cmpl_cnt(cmpl_cnt), .dly_cnt(dly_cnt),
    .ch_run(ch_run), .ch_halted(ch_halted), .ch_idle(ch_idle),
    .cur_desc(cur_desc), .tail_desc(tail_desc), .tx_kick(tx_kick)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
    if (!bus_rvalid) begin
      checks++; errors++;
      $display("FAIL R9 rvalid missing: actual=0 expected=1");
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R2", "run", ch_run, 2'b00);
    check("R2", "halted", ch_halted, 2'b11);
    check("R2", "idle", ch_idle, 2'b00);
    check("R2", "kick", tx_kick, 1'b0);
    check("R2", "rvalid", bus_rvalid, 1'b0);
    rd(8'h00, d); check("R2", "tx ctrl", d, 32'h0001_0002);
    rd(8'h04, d); check("R7", "tx status", d, 32'hC35A_0001);
    rd(8'h34, d); check("R7", "rx status", d, 32'h2211_0001);
    rd(8'h08, d); check("R2", "tx cur", d, 0);
    rd(8'h40, d); check("R2", "rx tail", d, 0);
  endtask

  task automatic t_decode();
    logic [31:0] d;
    wr(8'h08, 32'h1000_0040);
    wr(8'h38, 32'h2000_0080);
    check("R10", "cur outputs", cur_desc, 64'h2000_0080_1000_0040);
    rd(8'h38, d); check("R10", "rx cur read", d, 32'h2000_0080);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h0C, d); check("R1", "unmapped read", d, 0);
    check("R1", "unmapped write no effect", cur_desc, 64'h2000_0080_1000_0040);
    rd(8'h60, d); check("R1", "alias window 2 ctrl", d, 32'h0001_0002);
    wr(8'h68, 32'hABCD_0000);
    check("R1", "alias write tx cur", cur_desc[31:0], 32'hABCD_0000);
  endtask

  task automatic t_run();
    logic [31:0] d;
    wr(8'h30, 32'h0001_0001);
    check("R4", "rx halted cleared", ch_halted, 2'b01);
    check("R3", "rx run", ch_run, 2'b10);
    rd(8'h30, d); check("R3", "rx ctrl mode bit forced", d, 32'h0001_0003);
  endtask

  task automatic t_status_tail_rx();
    logic [31:0] d;
    wr(8'h34, 32'h0000_7003);
    rd(8'h34, d); check("R7", "status write masks 14:12", d, 32'h2211_0003);
    check("R7", "idle set by status write", ch_idle, 2'b10);
    wr(8'h40, 32'h3000_0000);
    check("R8", "rx tail clears idle", ch_idle, 2'b00);
    check("R8", "rx tail no kick", tx_kick, 1'b0);
    @(negedge clk);
    check("R8", "rx tail no kick later", tx_kick, 1'b0);
    check("R10", "tail outputs", tail_desc, 64'h3000_0000_0000_0000);
  endtask

  task automatic t_tail_tx();
    wr(8'h10, 32'h1000_0100);
    check("R8", "tx kick high", tx_kick, 1'b1);
    @(negedge clk);
    check("R8", "tx kick one clock", tx_kick, 1'b0);
    check("R10", "tx tail out", tail_desc[31:0], 32'h1000_0100);
  endtask

  task automatic t_soft_reset();
    logic [31:0] d;
    wr(8'h00, 32'h0000_0001);
    check("R4", "tx running", ch_halted[0], 1'b0);
    wr(8'h00, 32'h00FF_0005);
    check("R5", "tx halted after reset", ch_halted[0], 1'b1);
    check("R5", "tx run dropped", ch_run[0], 1'b0);
    wr(8'h00, 32'h0000_0001);
    check("R5", "run blocked while pending", ch_halted[0], 1'b1);
    rd(8'h00, d); check("R6", "first ctrl read shows reset", d, 32'h0001_0006);
    rd(8'h00, d); check("R6", "second ctrl read cleared", d, 32'h0001_0002);
    wr(8'h00, 32'h0000_0001);
    check("R4", "run after reset clear", ch_halted[0], 1'b0);
    rd(8'h00, d); check("R3", "ctrl stored", d, 32'h0000_0003);
  endtask

  task automatic t_wr_rd_same();
    logic [31:0] d;
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 8'h38; bus_wdata = 32'h5555_0000;
    @(negedge clk);
    bus_wr = 1'b0; bus_rd = 1'b0;
    check("R9", "no rvalid when both", bus_rvalid, 1'b0);
    rd(8'h38, d); check("R9", "write won", d, 32'h5555_0000);
    @(negedge clk);
    check("R9", "rvalid single clock", bus_rvalid, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_run();
    t_status_tail_rx();
    t_tail_tx();
    t_soft_reset();
    t_wr_rd_same();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule